// File: doc/BRIEF.md
# Indexed Secondary Configuration Register Window

This block gives a host access to four 8-bit parallel-port configuration registers through an index/data pair. The host writes a second-level offset into the index location. It then reads or writes the data location, and that access reaches the configuration register chosen by the offset. The host port is synchronous and has two addresses: index and data. A single strobe in a clock cycle marks a read or a write.

Only four offset codes are decoded: 0, 2, 4 and 5. Accesses through the data location at any other offset are dropped. The index keeps only its low three bits; its upper bits read back as zero. A global enable input comes from a higher-level configuration bit. While that enable is low, the pair cannot be reached at all.

The four configuration registers drive output ports continuously, so the rest of the port can use them. Each register takes a parameterized default value on reset. Its value is kept when the enable is toggled; it is reloaded only on reset.

Top module: `cfgx_window`

## Requirements
- R1: The index offset (bits 2:0) selects a register for data accesses: 3'b000 selects `ctl_a`, 3'b010 selects `ctl_b`, 3'b100 selects `ctl_c` and 3'b101 selects `pp_cfg`. A data read returns the selected register.
- R2: A data write while the offset is 1, 3, 6 or 7 changes no configuration register.
- R3: Index bits 7:3 are read-only and always read as 0. A written value keeps only bits 2:0.
- R4: While `cfg_en` is 0, writes to either address are ignored and every read returns 8'h00.
- R5: A data write at a supported offset updates the selected register at the clock edge of the write strobe. The new value is on the matching output port and in data reads from the next cycle.
- R6: A data read while the offset is unsupported returns 8'h00.
- R7: After reset, the index is 3'b000 and the four registers hold their default parameters.
- R8: Taking `cfg_en` low and back high does not reload the defaults, and it does not change the registers or the index.
- R9: An index read returns {5'b00000, offset}. Address select `host_sel` is 0 for the index location and 1 for the data location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | Higher-level enable for the index/data pair |
| host_sel | input | 1 | 0 = index location, 1 = data location |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| ctl_a | output | 8 | Configuration register at offset 0 |
| ctl_b | output | 8 | Configuration register at offset 2 |
| ctl_c | output | 8 | Configuration register at offset 4 |
| pp_cfg | output | 8 | Configuration register at offset 5 |

## Verification
Read data is combinational from the stored state. A read result therefore belongs to the same cycle as its strobe: the bench raises the strobe after a falling edge and samples before the next rising edge. A write lands at the one rising edge where its strobe is high. The bench checks the result through an output port or a read in the following cycle, and never in the cycle of the write. When reset is released, the internal synchronizer adds two cycles before access opens, and the bench waits past them before its first check.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned OFS_W = 3;
  localparam int unsigned NREG  = 4;

  // decoded second-level offsets, slot order fixed by the output ports
  function automatic logic [OFS_W-1:0] slot_offset(input int unsigned slot);
    case (slot)
      0:       slot_offset = 3'd0;
      1:       slot_offset = 3'd2;
      2:       slot_offset = 3'd4;
      default: slot_offset = 3'd5;
    endcase
  endfunction
endpackage

// File: rtl/cfgx_rst_sync.sv
module cfgx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cfgx_index.sv
module cfgx_index
  import cfgx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  output logic [OFS_W-1:0] offset
);
  logic [OFS_W-1:0] offset_q, offset_d;

  always_comb begin
    offset_d = offset_q;
    if (wr_en) offset_d = wdata[OFS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) offset_q <= '0;
    else        offset_q <= offset_d;
  end

  assign offset = offset_q;

  // R3: only the low bits are held
  a_r3_index_low_bits : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> offset == $past(wdata[OFS_W-1:0]));
endmodule

// File: rtl/cfgx_bank.sv
module cfgx_bank
  import cfgx_pkg::*;
#(
  parameter logic [DW-1:0] DEF_A = 8'h1C,
  parameter logic [DW-1:0] DEF_B = 8'h5A,
  parameter logic [DW-1:0] DEF_C = 8'h03,
  parameter logic [DW-1:0] DEF_P = 8'h60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] offset,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    regs [NREG],
  output logic             hit,
  output logic [DW-1:0]    sel_data
);
  logic [NREG-1:0] match;

  for (genvar s = 0; s < NREG; s++) begin : g_slot
    localparam logic [OFS_W-1:0] SLOT_OFS = slot_offset(s);
    localparam logic [DW-1:0] SLOT_DEF =
      (s == 0) ? DEF_A : (s == 1) ? DEF_B : (s == 2) ? DEF_C : DEF_P;
    logic [DW-1:0] val_q, val_d;

    assign match[s] = (offset == SLOT_OFS);

    always_comb begin
      val_d = val_q;
      if (wr_en && match[s]) val_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= SLOT_DEF;
      else        val_q <= val_d;
    end

    assign regs[s] = val_q;

    // R5: a write at this slot's offset lands on the next edge
    a_r5_write_lands : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && offset == SLOT_OFS) |=> val_q == $past(wdata));
  end

  assign hit = |match;

  always_comb begin
    sel_data = '0;
    for (int s = 0; s < NREG; s++)
      if (match[s]) sel_data = regs[s];
  end

  // R2: a write at an undecoded offset leaves every register unchanged
  a_r2_bad_offset_no_change : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> ($stable(regs[0]) && $stable(regs[1]) &&
                         $stable(regs[2]) && $stable(regs[3])));
  a_r1_onehot_match : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/cfgx_window.sv
module cfgx_window
  import cfgx_pkg::*;
#(
  parameter logic [7:0] DEF_A = 8'h1C,
  parameter logic [7:0] DEF_B = 8'h5A,
  parameter logic [7:0] DEF_C = 8'h03,
  parameter logic [7:0] DEF_P = 8'h60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_en,
  input  logic       host_sel,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic [7:0] ctl_a,
  output logic [7:0] ctl_b,
  output logic [7:0] ctl_c,
  output logic [7:0] pp_cfg
);
  logic             rst_i_n;
  logic             idx_we, dat_we;
  logic [OFS_W-1:0] offset;
  logic [DW-1:0]    regs [NREG];
  logic             hit;
  logic [DW-1:0]    sel_data;

  cfgx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  assign idx_we = cfg_en && host_wr && !host_sel;
  assign dat_we = cfg_en && host_wr &&  host_sel;

  cfgx_index u_index (
    .clk(clk), .rst_n(rst_i_n), .wr_en(idx_we),
    .wdata(host_wdata), .offset(offset)
  );

  cfgx_bank #(.DEF_A(DEF_A), .DEF_B(DEF_B), .DEF_C(DEF_C), .DEF_P(DEF_P)) u_bank (
    .clk(clk), .rst_n(rst_i_n), .wr_en(dat_we), .offset(offset),
    .wdata(host_wdata), .regs(regs), .hit(hit), .sel_data(sel_data)
  );

  always_comb begin
    host_rdata = '0;
    if (cfg_en && host_rd) begin
      if (!host_sel)  host_rdata = {{(DW-OFS_W){1'b0}}, offset};
      else if (hit)   host_rdata = sel_data;
    end
  end

  assign ctl_a  = regs[0];
  assign ctl_b  = regs[1];
  assign ctl_c  = regs[2];
  assign pp_cfg = regs[3];

  // R4: nothing moves and reads are zero while disabled
  a_r4_disabled_frozen : assert property (@(posedge clk) disable iff (!rst_i_n)
    !cfg_en |=> ($stable(offset) && $stable(ctl_a) && $stable(ctl_b) &&
                 $stable(ctl_c) && $stable(pp_cfg)));
  a_r4_disabled_read_zero : assert property (@(posedge clk) disable iff (!rst_i_n)
    !cfg_en |-> host_rdata == 8'h00);
  // R3: upper index bits never read as one
  a_r3_upper_zero : assert property (@(posedge clk) disable iff (!rst_i_n)
    (host_rd && !host_sel) |-> host_rdata[7:3] == 5'b0);
  // R6: unsupported offset reads zero
  a_r6_bad_read_zero : assert property (@(posedge clk) disable iff (!rst_i_n)
    (host_rd && host_sel && offset inside {3'd1, 3'd3, 3'd6, 3'd7}) |-> host_rdata == 8'h00);
endmodule

// File: tb/cfgx_window_bench.sv
module cfgx_window_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic       host_sel = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata, ctl_a, ctl_b, ctl_c, pp_cfg;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  cfgx_window u_cfgx_window (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .host_sel(host_sel),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ctl_a(ctl_a), .ctl_b(ctl_b),
    .ctl_c(ctl_c), .pp_cfg(pp_cfg)
  );

  // op: 0 write index, 1 write data, 2 read index, 3 read data
  localparam int NV = 27;
  localparam logic [17:0] VEC [NV] = '{
    {2'd2, 8'h00, 8'h00}, // R7 index after reset
    {2'd3, 8'h00, 8'h1C}, // R7 default a
    {2'd0, 8'h02, 8'h00}, {2'd3, 8'h00, 8'h5A}, // R1
    {2'd0, 8'h04, 8'h00}, {2'd3, 8'h00, 8'h03}, // R1
    {2'd0, 8'h05, 8'h00}, {2'd3, 8'h00, 8'h60}, // R1
    {2'd1, 8'hC3, 8'h00}, {2'd3, 8'h00, 8'hC3}, // R5
    {2'd0, 8'hFA, 8'h00}, {2'd2, 8'h00, 8'h02}, // R3 R9
    {2'd1, 8'h77, 8'h00}, {2'd3, 8'h00, 8'h77}, // R5
    {2'd0, 8'h01, 8'h00}, {2'd3, 8'h00, 8'h00}, // R6
    {2'd1, 8'hFF, 8'h00},                       // R2
    {2'd0, 8'h07, 8'h00}, {2'd1, 8'hEE, 8'h00}, {2'd3, 8'h00, 8'h00}, // R2 R6
    {2'd0, 8'h02, 8'h00}, {2'd3, 8'h00, 8'h77}, // R2 unchanged
    {2'd0, 8'h00, 8'h00}, {2'd3, 8'h00, 8'h1C},
    {2'd1, 8'h99, 8'h00}, {2'd3, 8'h00, 8'h99}, // R5
    {2'd2, 8'h00, 8'h00}                        // R9
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic do_read(input logic sel, output logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_rd = 1'b1;
    #2 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=00 expected=01");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    do_reset();
    cfg_en = 1'b1;
    check("R7 ctl_a", ctl_a, 8'h1C);
    check("R7 ctl_b", ctl_b, 8'h5A);
    check("R7 ctl_c", ctl_c, 8'h03);
    check("R7 pp_cfg", pp_cfg, 8'h60);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][17:16])
        2'd0: do_write(1'b0, VEC[i][15:8]);
        2'd1: do_write(1'b1, VEC[i][15:8]);
        2'd2: begin do_read(1'b0, rd); check("R9 R3 index read", rd, VEC[i][7:0]); end
        default: begin do_read(1'b1, rd); check("R1 R5 R6 data read", rd, VEC[i][7:0]); end
      endcase
    end

    check("R1 ctl_a port", ctl_a, 8'h99);
    check("R1 ctl_b port", ctl_b, 8'h77);
    check("R1 ctl_c port", ctl_c, 8'h03);
    check("R1 pp_cfg port", pp_cfg, 8'hC3);

    // R5: output port changes right after the write edge
    do_write(1'b0, 8'h04);
    @(negedge clk);
    host_sel = 1'b1; host_wdata = 8'hB4; host_wr = 1'b1;
    #2 check("R5 before edge", ctl_c, 8'h03);
    @(posedge clk); #2;
    check("R5 after edge", ctl_c, 8'hB4);
    @(negedge clk); host_wr = 1'b0;

    // R4: disabled pair
    cfg_en = 1'b0;
    do_write(1'b1, 8'h11);
    do_write(1'b0, 8'h00);
    do_read(1'b1, rd); check("R4 data read off", rd, 8'h00);
    do_read(1'b0, rd); check("R4 index read off", rd, 8'h00);
    check("R4 ctl_c kept", ctl_c, 8'hB4);
    check("R4 ctl_a kept", ctl_a, 8'h99);
    // R8: re-enable without reload
    cfg_en = 1'b1;
    do_read(1'b0, rd); check("R8 index kept", rd, 8'h04);
    do_read(1'b1, rd); check("R8 data kept", rd, 8'hB4);
    check("R8 pp_cfg kept", pp_cfg, 8'hC3);

    // R7: reset mid-run reloads defaults
    do_reset();
    check("R7 ctl_a again", ctl_a, 8'h1C);
    check("R7 ctl_c again", ctl_c, 8'h03);
    check("R7 pp_cfg again", pp_cfg, 8'h60);
    do_read(1'b0, rd); check("R7 index again", rd, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule